// File: doc/BRIEF.md
# Exclusive Access Monitor for a Shared AHB Slave

This block sits beside a slave that several AHB masters share. It watches the address phase of every transfer and keeps one reservation for each master. A reservation holds a 4-byte granule address and a valid flag. The block then tells the slave, in the data phase of each exclusive write, whether that write may take effect.

An exclusive read by a master opens (or replaces) that master's reservation. Later traffic can remove the reservation. A plain write from a different master to the reserved granule removes it. A successful exclusive write from a different master to that granule also removes it. A master's own plain writes leave its reservation in place. The master's exclusive write succeeds only if its reservation is still valid and covers the same granule. Every exclusive write by a master clears that master's reservation, whether the write passes or fails, so after a failure the whole read-modify-write sequence must start again. The block holds no data and does not suppress the write itself; the slave acts on the result.

Top module: `excl_monitor`

## Requirements
- R1: While `rst` is high and after it is released, every reservation is invalid and `exok` is 0. An exclusive write issued right after reset therefore fails.
- R2: A transfer is taken only at a rising edge where `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01) and any transfer seen while `hready` is 0 change no reservation and give no result.
- R3: A taken exclusive read (`hexcl`=1, `hwrite`=0) drives `exok`=1 in its data phase. It sets the issuing master's reservation to the granule it addressed.
- R4: A taken exclusive write passes (`exok`=1 in its data phase) when the issuing master's reservation is valid and holds the same granule.
- R5: Granules are compared on address bits [ADDR_W-1:2]. Bits [1:0] are ignored, so addresses 4 or more bytes apart are different granules.
- R6: An exclusive write from a master that has no valid reservation, or whose reservation holds a different granule, fails (`exok`=0).
- R7: Every taken exclusive write, pass or fail, clears the issuing master's reservation, so a second exclusive write without a new exclusive read fails.
- R8: A taken non-exclusive write from another master to a reserved granule clears that reservation. Reads from other masters clear nothing.
- R9: A master's own non-exclusive write, even to its reserved granule, leaves its reservation valid.
- R10: A new exclusive read from a master replaces its earlier reservation. The old granule is no longer reserved for that master.
- R11: A passing exclusive write clears the reservations that other masters hold on the same granule. A failing exclusive write clears no other master's reservation.
- R12: `exok` is 0 in the data phase of non-exclusive transfers and after idle cycles. While `hready` is 0 it holds its value for the whole data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hready | input | 1 | Bus ready; a transfer is taken only when it is 1 |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| haddr | input | ADDR_W | Byte address of the transfer |
| hmaster | input | ID_W | Index of the issuing master |
| hexcl | input | 1 | 1 marks an exclusive transfer |
| exok | output | 1 | Exclusive-okay result in the data phase |

## Verification
The bench builds the block with four masters and a 32-bit address. This gives two masters that contend for one granule and two bystanders, so a single run covers both clearing by another master's plain write and clearing by another master's passing exclusive write. Four masters also let a failed exclusive write from a third master be tested against a reservation that must survive it. With the full 32-bit address, granule aliasing through the low two bits and separation at a 4-byte step can both be tested. The hold behaviour is tested with wait states.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;

    // Reservations cover 4-byte granules.
    localparam int GRAN_LSB = 2;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    // True for transfer types that carry a real access.
    function automatic logic f_moves(input logic [1:0] t);
        return (t == TR_NSEQ) || (t == TR_SEQ);
    endfunction

    // Granule tag of a byte address, kept at full width.
    function automatic logic [63:0] f_granule(input logic [63:0] a);
        return a >> GRAN_LSB;
    endfunction

endpackage

// File: rtl/excl_addr_decode.sv
module excl_addr_decode
    import excl_monitor_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 2
) (
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [ID_W-1:0]   hmaster,
    input  logic              hexcl,
    output logic              acc,
    output logic              wr,
    output logic              ex,
    output logic [ADDR_W-1:0] gran,
    output logic [ID_W-1:0]   mid
);

    logic [63:0] gran_wide;

    always_comb begin
        acc       = hready && f_moves(htrans);
        wr        = hwrite;
        ex        = hexcl;
        mid       = hmaster;
        gran_wide = f_granule(64'(haddr));
        gran      = gran_wide[ADDR_W-1:0];
    end

endmodule

// File: rtl/excl_rsv_entry.sv
module excl_rsv_entry #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 2,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              wr,
    input  logic              ex,
    input  logic [ADDR_W-1:0] gran,
    input  logic [ID_W-1:0]   mid,
    input  logic              xw_pass,
    output logic              hit
);

    logic              valid_q;
    logic [ADDR_W-1:0] tag_q;
    logic              mine;
    logic              foreign_clear;

    always_comb begin
        mine = (mid == ID_W'(IDX));
        hit  = valid_q && (tag_q == gran);
        // Only writes that change memory remove another master's claim.
        foreign_clear = acc && !mine && wr && hit && (!ex || xw_pass);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (acc && mine && ex && !wr) begin
            valid_q <= 1'b1;
            tag_q   <= gran;
        end else if (acc && mine && ex && wr) begin
            valid_q <= 1'b0;
        end else if (foreign_clear) begin
            valid_q <= 1'b0;
        end
    end

    AST_XR_SETS: assert property (@(posedge clk) disable iff (rst)
        (acc && mine && ex && !wr) |=> valid_q); // R3
    AST_XW_CLEARS_OWN: assert property (@(posedge clk) disable iff (rst)
        (acc && mine && ex && wr) |=> !valid_q); // R7
    AST_OWN_WR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (acc && mine && wr && !ex && valid_q) |=> valid_q); // R9
    AST_OTHER_RD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (acc && !mine && !wr && valid_q) |=> valid_q); // R8

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_monitor_pkg::*;
#(
    parameter int  NUM_MASTERS = 4,
    parameter int  ADDR_W      = 32,
    localparam int ID_W        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [ID_W-1:0]   hmaster,
    input  logic              hexcl,
    output logic              exok
);

    logic                   acc;
    logic                   wr;
    logic                   ex;
    logic [ADDR_W-1:0]      gran;
    logic [ID_W-1:0]        mid;
    logic [NUM_MASTERS-1:0] hit;
    logic                   own_hit;
    logic                   xw_pass;
    logic                   pass;
    logic                   exok_q;

    excl_addr_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) i_decode (
        .hready (hready),
        .htrans (htrans),
        .hwrite (hwrite),
        .haddr  (haddr),
        .hmaster(hmaster),
        .hexcl  (hexcl),
        .acc    (acc),
        .wr     (wr),
        .ex     (ex),
        .gran   (gran),
        .mid    (mid)
    );

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_rsv
        excl_rsv_entry #(.ADDR_W(ADDR_W), .ID_W(ID_W), .IDX(g)) i_entry (
            .clk    (clk),
            .rst    (rst),
            .acc    (acc),
            .wr     (wr),
            .ex     (ex),
            .gran   (gran),
            .mid    (mid),
            .xw_pass(xw_pass),
            .hit    (hit[g])
        );
    end

    always_comb begin
        own_hit = 1'b0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (mid == ID_W'(i)) own_hit = hit[i];
        end
        xw_pass = ex && wr && own_hit;
        pass    = ex && (!wr || own_hit);
    end

    // Result register: loads at each ready edge, holds through wait states.
    always_ff @(posedge clk) begin
        if (rst) begin
            exok_q <= 1'b0;
        end else if (hready) begin
            exok_q <= acc && pass;
        end
    end

    assign exok = exok_q;

    AST_EXOK_NEEDS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $rose(exok) |-> $past(hexcl && hready)); // R3
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !hready |=> $stable(exok)); // R12
    AST_IDLE_NO_EXOK: assert property (@(posedge clk) disable iff (rst)
        (hready && !htrans[1]) |=> !exok); // R2
    AST_XW_NO_RSV_FAILS: assert property (@(posedge clk) disable iff (rst)
        (hready && htrans[1] && hexcl && hwrite && !own_hit) |=> !exok); // R6
    AST_PLAIN_NO_EXOK: assert property (@(posedge clk) disable iff (rst)
        (hready && !hexcl) |=> !exok); // R12

endmodule

// File: tb/test_excl_monitor.sv
module test_excl_monitor;

    localparam int NM = 4;
    localparam int AW = 32;
    localparam int NV = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hready = 1'b1;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    hmaster = '0;
    logic          hexcl = 1'b0;
    logic          exok;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    excl_monitor #(.NUM_MASTERS(NM), .ADDR_W(AW)) i_excl_monitor (
        .clk(clk), .rst(rst), .hready(hready), .htrans(htrans),
        .hwrite(hwrite), .haddr(haddr), .hmaster(hmaster),
        .hexcl(hexcl), .exok(exok)
    );

    // {master, write, excl, trans, addr, expected exok}
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b1, 2'b10, 32'h100, 1'b1},  // R3 read opens
        {2'd0, 1'b1, 1'b1, 2'b10, 32'h102, 1'b1},  // R4 R5 same granule
        {2'd0, 1'b1, 1'b1, 2'b10, 32'h100, 1'b0},  // R7 second write
        {2'd1, 1'b0, 1'b1, 2'b10, 32'h200, 1'b1},  // R3
        {2'd2, 1'b1, 1'b0, 2'b10, 32'h200, 1'b0},  // R12 plain write
        {2'd1, 1'b1, 1'b1, 2'b10, 32'h200, 1'b0},  // R8 cleared
        {2'd1, 1'b0, 1'b1, 2'b10, 32'h300, 1'b1},  // R3
        {2'd1, 1'b1, 1'b0, 2'b10, 32'h300, 1'b0},  // R9 own plain write
        {2'd1, 1'b1, 1'b1, 2'b10, 32'h300, 1'b1},  // R9 still passes
        {2'd2, 1'b0, 1'b1, 2'b10, 32'h400, 1'b1},  // R10
        {2'd2, 1'b0, 1'b1, 2'b10, 32'h500, 1'b1},  // R10 replace
        {2'd2, 1'b1, 1'b1, 2'b10, 32'h400, 1'b0},  // R10 old gone
        {2'd3, 1'b0, 1'b1, 2'b10, 32'h600, 1'b1},  // R11
        {2'd0, 1'b0, 1'b1, 2'b10, 32'h600, 1'b1},  // R11
        {2'd3, 1'b1, 1'b1, 2'b10, 32'h600, 1'b1},  // R11 winner
        {2'd0, 1'b1, 1'b1, 2'b10, 32'h600, 1'b0},  // R11 loser
        {2'd0, 1'b0, 1'b1, 2'b10, 32'h700, 1'b1},  // R11
        {2'd1, 1'b0, 1'b1, 2'b10, 32'h700, 1'b1},  // R11
        {2'd2, 1'b1, 1'b1, 2'b10, 32'h700, 1'b0},  // R6 no reservation
        {2'd0, 1'b1, 1'b1, 2'b10, 32'h700, 1'b1},  // R11 failed write left it
        {2'd1, 1'b1, 1'b1, 2'b10, 32'h700, 1'b0},  // R11 cleared by pass
        {2'd3, 1'b0, 1'b1, 2'b00, 32'h800, 1'b0},  // R2 idle ignored
        {2'd3, 1'b1, 1'b1, 2'b10, 32'h800, 1'b0},  // R2 nothing reserved
        {2'd3, 1'b0, 1'b1, 2'b01, 32'h800, 1'b0},  // R2 busy ignored
        {2'd3, 1'b0, 1'b1, 2'b11, 32'h900, 1'b1},  // R2 seq taken
        {2'd3, 1'b1, 1'b1, 2'b11, 32'h904, 1'b0},  // R5 R6 next granule
        {2'd1, 1'b0, 1'b1, 2'b10, 32'hB00, 1'b1},  // R3
        {2'd2, 1'b0, 1'b0, 2'b10, 32'hB00, 1'b0},  // R8 R12 other read
        {2'd1, 1'b1, 1'b1, 2'b10, 32'hB00, 1'b1}   // R8 read kept it
    };
    localparam int VREQ [NV] = '{3, 4, 7, 3, 12, 8, 3, 9, 9, 10, 10, 10, 11, 11,
                                 11, 11, 11, 11, 6, 11, 11, 2, 2, 2, 2, 5, 3, 8, 8};

    task automatic check(input logic got, input logic exp, input int rq, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: exok=%b expected=%b", rq, what, got, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] m, input logic w, input logic x,
                        input logic [1:0] t, input logic [31:0] a);
        hmaster = m; hwrite = w; hexcl = x; htrans = t; haddr = a;
        @(posedge clk); #1;
        htrans = 2'b00; hexcl = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(exok, 1'b0, 1, "exok low in reset");  // R1
        rst = 1'b0;
        @(posedge clk); #1;
        check(exok, 1'b0, 1, "exok low after reset");  // R1
        xfer(2'd0, 1'b1, 1'b1, 2'b10, 32'h0);
        check(exok, 1'b0, 1, "write after reset has no reservation");  // R1

        for (int k = 0; k < NV; k++) begin
            xfer(VEC[k][38:37], VEC[k][36], VEC[k][35], VEC[k][34:33], VEC[k][32:1]);
            check(exok, VEC[k][0], VREQ[k], $sformatf("vector %0d", k));
        end

        // Wait state: result holds, stalled transfer is ignored (R12, R2).
        xfer(2'd0, 1'b0, 1'b1, 2'b10, 32'hC00);
        check(exok, 1'b1, 3, "read before wait");
        hready = 1'b0;
        xfer(2'd1, 1'b1, 1'b0, 2'b10, 32'hC00);
        check(exok, 1'b1, 12, "held in wait state");
        hready = 1'b1;
        xfer(2'd0, 1'b0, 1'b0, 2'b00, 32'h0);
        check(exok, 1'b0, 12, "low after idle");
        xfer(2'd0, 1'b1, 1'b1, 2'b10, 32'hC00);
        check(exok, 1'b1, 2, "write during wait was ignored");

        // Reset in the middle clears a reservation (R1).
        xfer(2'd1, 1'b0, 1'b1, 2'b10, 32'hE00);
        check(exok, 1'b1, 3, "read before reset");
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(exok, 1'b0, 1, "exok cleared by reset");
        rst = 1'b0;
        xfer(2'd1, 1'b1, 1'b1, 2'b10, 32'hE00);
        check(exok, 1'b0, 1, "reservation lost to reset");

        finish_run();
    end

endmodule